// File: doc/BRIEF.md
# Coprocessor Byte Mailbox and Port Decoder

This block sits between a host processor bus and a Z80 coprocessor and lets the two exchange single bytes. Each direction has its own byte register and its own pending flag. The coprocessor reaches the block through its I/O port space. Only the top three address bits select the port group, so every group covers 32 addresses. The host side has three parts: a write strobe that loads the byte going to the coprocessor, a read strobe that takes the byte coming from the coprocessor, and two strobes that clear the flags directly.

Two control port groups also drive the coprocessor's memory mapper. One sets the boot-shadow enable. The other sets a bank number and a common-area enable. These values leave the block as plain level outputs.

Read data on the coprocessor side is combinational and depends on the current state. When a read or write changes a flag, the change takes effect at the clock edge that ends the access.

Top module: `cpmb_mailbox`

## Requirements
- R1: After reset, `map_shadow` is 1. `map_bank`, `map_common`, `to_host_pend` and `to_z_pend` are 0. Both data registers hold 0x00, and `z_rdata` is 0x00 while no access is active.
- R2: The port group comes only from `z_addr[7:5]`. Group 0 is outbound data, group 1 is inbound data, group 2 is status, group 3 is shadow control and group 6 is bank control. `z_addr[4:0]` has no effect.
- R3: A coprocessor write to group 0 stores `z_wdata` in the outbound register, which `host_rdata` shows from the next cycle. The same write sets `to_host_pend`.
- R4: A coprocessor read of group 0 returns the outbound register and changes no flag.
- R5: A `host_wr_in` pulse stores `host_wdata` in the inbound register and sets `to_z_pend`. A coprocessor read of group 1 returns that byte, and `to_z_pend` is 0 from the next cycle.
- R6: A read of group 2 returns bit 7 equal to `to_z_pend` and bit 0 equal to `to_host_pend`. Bits 6:1 read 0.
- R7: A `host_rd_out` pulse clears `to_host_pend`. A `host_clr_tohost` pulse clears `to_host_pend`, and a `host_clr_toz` pulse clears `to_z_pend`.
- R8: A write to group 3 loads `map_shadow` from `z_wdata[0]`.
- R9: A write to group 6 loads `map_bank` from `z_wdata[3:1]` and `map_common` from `z_wdata[6]`.
- R10: A read of groups 3 through 7 returns 0x00. A write to groups 1, 2, 4, 5 or 7 changes no output.
- R11: When a flag is set and cleared in the same cycle, the set takes effect and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| z_io_en | input | 1 | Coprocessor I/O access active this cycle |
| z_wr | input | 1 | 1 = write access, 0 = read access |
| z_addr | input | 8 | Coprocessor I/O port address |
| z_wdata | input | 8 | Coprocessor write data |
| z_rdata | output | 8 | Coprocessor read data (combinational) |
| host_wr_in | input | 1 | Host writes the inbound byte |
| host_wdata | input | 8 | Host write data |
| host_rd_out | input | 1 | Host takes the outbound byte |
| host_rdata | output | 8 | Outbound byte as seen by the host |
| host_clr_tohost | input | 1 | Host clears the outbound pending flag |
| host_clr_toz | input | 1 | Host clears the inbound pending flag |
| to_host_pend | output | 1 | Outbound byte waiting for the host |
| to_z_pend | output | 1 | Inbound byte waiting for the coprocessor |
| map_shadow | output | 1 | Boot-shadow enable to the mapper |
| map_bank | output | 3 | Bank number to the mapper |
| map_common | output | 1 | Common-area enable to the mapper |

## Verification
The bench sets addresses with the low five bits set, such as 0x1F and 0xDF. A decoder that used those bits would send these accesses to the wrong group or ignore them. The bench drives a set and a clear of the same flag in one cycle, where a design with the priority reversed would drop a fresh byte's pending flag. It writes to the inbound, status and unused groups and reads the write-only control groups. A design that decoded these accesses loosely would change the mapper outputs or return stale data. Bank values with bit 0 set check that the bank field is taken from bits 3:1 and not 2:0.

// File: rtl/cpmb_pkg.sv
package cpmb_pkg;
  localparam int GRP_W = 3;
  localparam logic [GRP_W-1:0] GRP_OUT    = 3'd0;
  localparam logic [GRP_W-1:0] GRP_IN     = 3'd1;
  localparam logic [GRP_W-1:0] GRP_STAT   = 3'd2;
  localparam logic [GRP_W-1:0] GRP_SHADOW = 3'd3;
  localparam logic [GRP_W-1:0] GRP_BANK   = 3'd6;

  // port group = top three address bits
  function automatic logic [GRP_W-1:0] port_group(input logic [7:0] addr);
    return addr[7:5];
  endfunction

  // bank number lives in data bits 3:1
  function automatic logic [2:0] bank_field(input logic [7:0] d);
    return d[3:1];
  endfunction

  function automatic logic common_field(input logic [7:0] d);
    return d[6];
  endfunction

  // status byte: coprocessor-side flag in bit 7, host-side flag in bit 0
  function automatic logic [7:0] status_byte(input logic z_pend, input logic h_pend);
    return {z_pend, 6'b000000, h_pend};
  endfunction
endpackage

// File: rtl/cpmb_port_decode.sv
module cpmb_port_decode
  import cpmb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              io_en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_out,
  output logic              rd_out,
  output logic              rd_in,
  output logic              rd_stat,
  output logic              wr_shadow,
  output logic              wr_bank,
  output logic              rd_hit
);
  logic [GRP_W-1:0] grp;
  assign grp = port_group(addr[ADDR_W-1 -: 8]);

  always_comb begin
    wr_out    = io_en &&  wr && (grp == GRP_OUT);
    rd_out    = io_en && !wr && (grp == GRP_OUT);
    rd_in     = io_en && !wr && (grp == GRP_IN);
    rd_stat   = io_en && !wr && (grp == GRP_STAT);
    wr_shadow = io_en &&  wr && (grp == GRP_SHADOW);
    wr_bank   = io_en &&  wr && (grp == GRP_BANK);
    rd_hit    = rd_out || rd_in || rd_stat;
  end
endmodule

// File: rtl/cpmb_mbox_slot.sv
module cpmb_mbox_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              drain,
  output logic [DATA_W-1:0] data,
  output logic              pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      pend <= 1'b0;
    end else begin
      if (load) data <= ld_data;
      if (load)       pend <= 1'b1;
      else if (drain) pend <= 1'b0;
    end
  end

  // R3
  load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pend && data == $past(ld_data)));
  // R7
  drain_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !load) |=> !pend);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && load) |=> pend);
endmodule

// File: rtl/cpmb_map_ctrl.sv
module cpmb_map_ctrl
  import cpmb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_shadow,
  input  logic              wr_bank,
  input  logic [DATA_W-1:0] wdata,
  output logic              shadow,
  output logic [2:0]        bank,
  output logic              common
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= 1'b1;
      bank   <= '0;
      common <= 1'b0;
    end else begin
      if (wr_shadow) shadow <= wdata[0];
      if (wr_bank) begin
        bank   <= bank_field(wdata[7:0]);
        common <= common_field(wdata[7:0]);
      end
    end
  end

  // R8
  shadow_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shadow |=> (shadow == $past(wdata[0])));
  // R10
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_shadow && !wr_bank) |=> ($stable(shadow) && $stable(bank) && $stable(common)));
endmodule

// File: rtl/cpmb_mailbox.sv
module cpmb_mailbox
  import cpmb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              z_io_en,
  input  logic              z_wr,
  input  logic [ADDR_W-1:0] z_addr,
  input  logic [DATA_W-1:0] z_wdata,
  output logic [DATA_W-1:0] z_rdata,
  input  logic              host_wr_in,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_out,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              host_clr_tohost,
  input  logic              host_clr_toz,
  output logic              to_host_pend,
  output logic              to_z_pend,
  output logic              map_shadow,
  output logic [2:0]        map_bank,
  output logic              map_common
);
  logic dec_wr_out, dec_rd_out, dec_rd_in, dec_rd_stat;
  logic dec_wr_shadow, dec_wr_bank, dec_rd_hit;
  logic [DATA_W-1:0] in_data;
  logic host_drain, z_drain;

  cpmb_port_decode #(.ADDR_W(ADDR_W)) dec_i (
    .io_en(z_io_en), .wr(z_wr), .addr(z_addr),
    .wr_out(dec_wr_out), .rd_out(dec_rd_out), .rd_in(dec_rd_in),
    .rd_stat(dec_rd_stat), .wr_shadow(dec_wr_shadow), .wr_bank(dec_wr_bank),
    .rd_hit(dec_rd_hit)
  );

  assign host_drain = host_rd_out || host_clr_tohost;
  assign z_drain    = dec_rd_in || host_clr_toz;

  cpmb_mbox_slot #(.DATA_W(DATA_W)) out_slot_i (
    .clk(clk), .rst_n(rst_n), .load(dec_wr_out), .ld_data(z_wdata),
    .drain(host_drain), .data(host_rdata), .pend(to_host_pend)
  );

  cpmb_mbox_slot #(.DATA_W(DATA_W)) in_slot_i (
    .clk(clk), .rst_n(rst_n), .load(host_wr_in), .ld_data(host_wdata),
    .drain(z_drain), .data(in_data), .pend(to_z_pend)
  );

  cpmb_map_ctrl #(.DATA_W(DATA_W)) map_i (
    .clk(clk), .rst_n(rst_n), .wr_shadow(dec_wr_shadow), .wr_bank(dec_wr_bank),
    .wdata(z_wdata), .shadow(map_shadow), .bank(map_bank), .common(map_common)
  );

  always_comb begin
    z_rdata = '0;
    if (dec_rd_out)  z_rdata = host_rdata;
    if (dec_rd_in)   z_rdata = in_data;
    if (dec_rd_stat) z_rdata = DATA_W'(status_byte(to_z_pend, to_host_pend));
  end

  // R10
  undec_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_rd_hit) |-> (z_rdata == '0));
  // R6
  stat_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_rd_stat |-> (z_rdata[6:1] == 6'd0));
  // R5
  in_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rd_in && !host_wr_in) |=> !to_z_pend);
endmodule

// File: tb/cpmb_mailbox_tb_top.sv
module cpmb_mailbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       z_io_en = 1'b0, z_wr = 1'b0;
  logic [7:0] z_addr = '0, z_wdata = '0, host_wdata = '0;
  logic       host_wr_in = 1'b0, host_rd_out = 1'b0;
  logic       host_clr_tohost = 1'b0, host_clr_toz = 1'b0;
  logic [7:0] z_rdata, host_rdata;
  logic       to_host_pend, to_z_pend, map_shadow, map_common;
  logic [2:0] map_bank;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cpmb_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .z_io_en(z_io_en), .z_wr(z_wr), .z_addr(z_addr),
    .z_wdata(z_wdata), .z_rdata(z_rdata), .host_wr_in(host_wr_in),
    .host_wdata(host_wdata), .host_rd_out(host_rd_out), .host_rdata(host_rdata),
    .host_clr_tohost(host_clr_tohost), .host_clr_toz(host_clr_toz),
    .to_host_pend(to_host_pend), .to_z_pend(to_z_pend), .map_shadow(map_shadow),
    .map_bank(map_bank), .map_common(map_common)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic zp, input logic hp);
    logic [7:0] s = 8'h00;
    s[7] = zp;
    s[0] = hp;
    return s;
  endfunction

  task automatic z_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    z_io_en = 1; z_wr = 1; z_addr = a; z_wdata = d;
    @(negedge clk);
    z_io_en = 0; z_wr = 0;
  endtask

  task automatic z_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    z_io_en = 1; z_wr = 0; z_addr = a;
    #2 d = z_rdata;
    @(negedge clk);
    z_io_en = 0;
  endtask

  task automatic host_put(input logic [7:0] d);
    @(negedge clk);
    host_wr_in = 1; host_wdata = d;
    @(negedge clk);
    host_wr_in = 0;
  endtask

  task automatic pulse_rd_out();
    @(negedge clk); host_rd_out = 1;
    @(negedge clk); host_rd_out = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 shadow", {7'd0, map_shadow}, 8'h01);
    chk("R1 bank", {5'd0, map_bank}, 8'h00);
    chk("R1 common", {7'd0, map_common}, 8'h00);
    chk("R1 flags", {6'd0, to_z_pend, to_host_pend}, 8'h00);
    chk("R1 host_rdata", host_rdata, 8'h00);
    chk("R1 idle z_rdata", z_rdata, 8'h00);
  endtask

  task automatic t_outbound();
    logic [7:0] d;
    z_write(8'h1F, 8'hA5);
    chk("R2 R3 host_rdata", host_rdata, 8'hA5);
    chk("R3 to_host_pend", {7'd0, to_host_pend}, 8'h01);
    z_read(8'h0C, d);
    chk("R4 read outbound", d, 8'hA5);
    chk("R4 flag kept", {7'd0, to_host_pend}, 8'h01);
    z_read(8'h5E, d);
    chk("R6 status host only", d, exp_status(1'b0, 1'b1));
    pulse_rd_out();
    chk("R7 host read clears", {7'd0, to_host_pend}, 8'h00);
  endtask

  task automatic t_inbound();
    logic [7:0] d;
    host_put(8'h3C);
    chk("R5 to_z_pend set", {7'd0, to_z_pend}, 8'h01);
    z_read(8'h40, d);
    chk("R6 status z only", d, exp_status(1'b1, 1'b0));
    z_read(8'h25, d);
    chk("R5 inbound data", d, 8'h3C);
    chk("R5 to_z_pend cleared", {7'd0, to_z_pend}, 8'h00);
    z_read(8'h5F, d);
    chk("R6 status empty", d, exp_status(1'b0, 1'b0));
  endtask

  task automatic t_both_and_clear();
    logic [7:0] d;
    host_put(8'h11);
    z_write(8'h00, 8'h22);
    z_read(8'h41, d);
    chk("R6 status both", d, exp_status(1'b1, 1'b1));
    @(negedge clk); host_clr_tohost = 1;
    @(negedge clk); host_clr_tohost = 0;
    chk("R7 clr_tohost", {6'd0, to_z_pend, to_host_pend}, 8'h02);
    @(negedge clk); host_clr_toz = 1;
    @(negedge clk); host_clr_toz = 0;
    chk("R7 clr_toz", {6'd0, to_z_pend, to_host_pend}, 8'h00);
  endtask

  task automatic t_map();
    z_write(8'h60, 8'hFE);
    chk("R8 shadow off", {7'd0, map_shadow}, 8'h00);
    z_write(8'h7F, 8'h01);
    chk("R8 R2 shadow on", {7'd0, map_shadow}, 8'h01);
    z_write(8'hC0, 8'h4E);
    chk("R9 bank 7", {5'd0, map_bank}, 8'h07);
    chk("R9 common 1", {7'd0, map_common}, 8'h01);
    z_write(8'hDF, 8'h0B);
    chk("R9 R2 bank 5", {5'd0, map_bank}, 8'h05);
    chk("R9 common 0", {7'd0, map_common}, 8'h00);
  endtask

  task automatic t_undecoded();
    logic [7:0] d;
    z_read(8'h60, d); chk("R10 read grp3", d, 8'h00);
    z_read(8'h80, d); chk("R10 read grp4", d, 8'h00);
    z_read(8'hA7, d); chk("R10 read grp5", d, 8'h00);
    z_read(8'hC0, d); chk("R10 read grp6", d, 8'h00);
    z_read(8'hE0, d); chk("R10 read grp7", d, 8'h00);
    z_write(8'h20, 8'hFF);
    z_write(8'h40, 8'hFF);
    z_write(8'h80, 8'hFF);
    z_write(8'hA0, 8'hFF);
    z_write(8'hE0, 8'hFF);
    chk("R10 flags kept", {6'd0, to_z_pend, to_host_pend}, 8'h00);
    chk("R10 host_rdata kept", host_rdata, 8'h22);
    chk("R10 map kept", {3'd0, map_shadow, map_bank, map_common}, 8'h1A);
    z_read(8'h20, d); chk("R10 inbound kept", d, 8'h11);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    z_write(8'h00, 8'h55);
    @(negedge clk);
    z_io_en = 1; z_wr = 1; z_addr = 8'h03; z_wdata = 8'h66; host_rd_out = 1;
    @(negedge clk);
    z_io_en = 0; z_wr = 0; host_rd_out = 0;
    chk("R11 outbound set wins", {7'd0, to_host_pend}, 8'h01);
    chk("R11 outbound data", host_rdata, 8'h66);
    @(negedge clk);
    z_io_en = 1; z_wr = 0; z_addr = 8'h20; host_wr_in = 1; host_wdata = 8'h77;
    #2 d = z_rdata;
    @(negedge clk);
    z_io_en = 0; host_wr_in = 0;
    chk("R11 old inbound read", d, 8'h11);
    chk("R11 inbound set wins", {7'd0, to_z_pend}, 8'h01);
    z_read(8'h20, d);
    chk("R11 new inbound", d, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_outbound();
    t_inbound();
    t_both_and_clear();
    t_map();
    t_undecoded();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule